// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Receiver

This block recovers asynchronous serial frames from one receive line and hands the words to a host through a small queue. A clock enable at sixteen times the bit rate drives a recovery stage. That stage confirms each start bit at its middle sample and then decides every data bit and the stop bit by a vote of three samples around the middle of the bit. Each frame carries either eight or nine data bits, least significant bit first, and a stop bit follows the data.

Completed words go into a two-entry queue. Each entry stores the data byte, the ninth bit and the framing-error bit of that frame, so the status the host sees always belongs to the word at the head. The host reads the head and removes it with a one-cycle pop strobe. A data-available level is high while the queue is not empty, and the interrupt output is that level gated by an enable.

On a multidrop bus, nine-bit mode with the address filter switched on keeps only frames whose ninth bit is set, so a node sees only address frames until the host turns the filter off. If a frame completes while the queue is full, the overrun flag is set. From then on every frame is dropped, while the queued words stay readable. Only pulling the receive enable low clears the overrun flag.

Top module: `mdrop_uart_rx`

## Requirements
- R1: A frame is a low start bit, then the data bits least significant first, then a stop bit. In eight-bit mode the byte appears on `head_data` and `head_bit9` reads 0.
- R2: A start bit counts only if the line is still low at the eighth oversample of the start bit. A shorter low pulse produces no word.
- R3: Each data bit takes the majority of the 7th, 8th and 9th oversamples of its bit period, so one wrong oversample in a bit does not change the received word.
- R4: With `nine_bit_en` high, a frame carries nine data bits and the ninth is delivered on `head_bit9` together with its byte.
- R5: With both `nine_bit_en` and `addr_match_en` high, a frame whose ninth bit is 0 is dropped: the queue is unchanged and `data_avail` stays low.
- R6: With `addr_match_en` low, every frame is stored, including nine-bit frames whose ninth bit is 0.
- R7: A stop bit sampled low still stores the word, and `head_ferr` reads 1 for that word only.
- R8: The queue holds two words and delivers them in arrival order. A pop strobe while data is available moves to the next word.
- R9: A frame that completes while two words are held sets `overrun_err` and is dropped. While `overrun_err` is set, every new frame is dropped and the held words stay unchanged.
- R10: `rx_en` low clears `overrun_err` in the next cycle, and reception works normally after `rx_en` returns high.
- R11: Frames are received only while both `port_en` and `rx_en` are high. A frame sent while either is low produces no word.
- R12: `data_avail` is high exactly while the queue holds a word, and `irq` equals `data_avail` AND `irq_en`.
- R13: After reset `data_avail`, `overrun_err` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Clock enable at 16x the bit rate |
| rx_line | input | 1 | Serial receive line, idle high |
| port_en | input | 1 | Serial port enable |
| rx_en | input | 1 | Receive enable; low clears overrun |
| nine_bit_en | input | 1 | Nine data bits per frame |
| addr_match_en | input | 1 | Drop nine-bit frames whose ninth bit is 0 |
| irq_en | input | 1 | Interrupt enable |
| pop_stb | input | 1 | Remove the head word (one cycle) |
| head_data | output | DATA_W | Data byte of the head word |
| head_bit9 | output | 1 | Ninth bit of the head word |
| head_ferr | output | 1 | Framing error of the head word |
| overrun_err | output | 1 | Sticky overrun flag |
| data_avail | output | 1 | Queue not empty |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest state to reach is an overrun: it needs a third frame while two unread words are held. After that comes a fourth frame that must be dropped without disturbing the held pair, and then the clear through the receive enable. The stimulus sends four back-to-back frames with no pops and then pops both held words. It checks that the queue is empty, sends another frame while the flag is still set, and only then toggles the enable. The majority vote is reached with a pulse of one sample-clock period inverted near a bit centre. Since that pulse covers exactly one oversample, the word must come out unchanged whatever the phase between line and tick.

// File: rtl/uarx_pkg.sv
package uarx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uarx_sync.sv
module uarx_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uarx_sampler.sv
module uarx_sampler
  import uarx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx,
  input  logic              active,
  input  logic              nine_bit,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o,
  output logic              b9_o,
  output logic              ferr_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] S_VA   = CNT_W'(OVS/2 - 2);
  localparam logic [CNT_W-1:0] S_MID  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] S_VC   = CNT_W'(OVS/2);
  localparam logic [CNT_W-1:0] S_LAST = CNT_W'(OVS - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] sidx;
  logic [BIT_W-1:0] bidx;
  logic [BIT_W-1:0] bit_last;
  logic             va, vb;
  logic [DATA_W:0]  shreg;
  logic             vote;

  assign bit_last = nine_bit ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);
  assign vote     = maj3(va, vb, rx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RX_IDLE;
      sidx   <= '0;
      bidx   <= '0;
      va     <= 1'b1;
      vb     <= 1'b1;
      shreg  <= '0;
      done_o <= 1'b0;
      word_o <= '0;
      b9_o   <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!active) begin
        state <= RX_IDLE;
      end else if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!rx) begin
              state <= RX_START;
              sidx  <= CNT_W'(1);
            end
          end
          RX_START: begin
            if (sidx == S_MID && rx) begin
              state <= RX_IDLE;
            end else if (sidx == S_LAST) begin
              state <= RX_DATA;
              sidx  <= '0;
              bidx  <= '0;
            end else begin
              sidx <= sidx + 1'b1;
            end
          end
          RX_DATA: begin
            if (sidx == S_VA)  va <= rx;
            if (sidx == S_MID) vb <= rx;
            if (sidx == S_VC)  shreg[bidx] <= vote;
            if (sidx == S_LAST) begin
              sidx <= '0;
              if (bidx == bit_last) state <= RX_STOP;
              else                  bidx  <= bidx + 1'b1;
            end else begin
              sidx <= sidx + 1'b1;
            end
          end
          RX_STOP: begin
            if (sidx == S_VA)  va <= rx;
            if (sidx == S_MID) vb <= rx;
            if (sidx == S_VC) begin
              done_o <= 1'b1;
              word_o <= shreg[DATA_W-1:0];
              b9_o   <= nine_bit & shreg[DATA_W];
              ferr_o <= ~vote;
              state  <= RX_IDLE;
            end else begin
              sidx <= sidx + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uarx_fifo.sv
module uarx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic [W-1:0]                   din,
  input  logic                           pop,
  output logic [W-1:0]                   head,
  output logic [$clog2(DEPTH+1)-1:0]     level,
  output logic                           full,
  output logic                           empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      level <= level + LVL_W'(push) - LVL_W'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx #(
  parameter int DATA_W     = 8,
  parameter int OVS        = 16,
  parameter int FIFO_DEPTH = 2,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_tick,
  input  logic              rx_line,
  input  logic              port_en,
  input  logic              rx_en,
  input  logic              nine_bit_en,
  input  logic              addr_match_en,
  input  logic              irq_en,
  input  logic              pop_stb,
  output logic [DATA_W-1:0] head_data,
  output logic              head_bit9,
  output logic              head_ferr,
  output logic              overrun_err,
  output logic              data_avail,
  output logic              irq
);
  localparam int ENT_W = DATA_W + 2;
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic              rx_s;
  logic              active;
  logic              f_done, f_b9, f_ferr;
  logic [DATA_W-1:0] f_word;
  logic              take, push, pop;
  logic              q_full, q_empty;
  logic [LVL_W-1:0]  fifo_level;
  logic [ENT_W-1:0]  q_head;

  assign active = port_en & rx_en;

  uarx_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (rx_line),
    .q   (rx_s)
  );

  uarx_sampler #(.DATA_W(DATA_W), .OVS(OVS)) samp_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (sample_tick),
    .rx       (rx_s),
    .active   (active),
    .nine_bit (nine_bit_en),
    .done_o   (f_done),
    .word_o   (f_word),
    .b9_o     (f_b9),
    .ferr_o   (f_ferr)
  );

  // address filter: in nine-bit mode with filtering on, only address frames pass
  assign take = f_done & (~(nine_bit_en & addr_match_en) | f_b9);
  assign push = take & ~overrun_err & ~q_full;
  assign pop  = pop_stb & ~q_empty;

  always_ff @(posedge clk) begin
    if (rst)                               overrun_err <= 1'b0;
    else if (!rx_en)                       overrun_err <= 1'b0;
    else if (take && q_full && !overrun_err) overrun_err <= 1'b1;
  end

  uarx_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .din   ({f_ferr, f_b9, f_word}),
    .pop   (pop),
    .head  (q_head),
    .level (fifo_level),
    .full  (q_full),
    .empty (q_empty)
  );

  assign head_data  = q_head[DATA_W-1:0];
  assign head_bit9  = q_head[DATA_W];
  assign head_ferr  = q_head[DATA_W+1];
  assign data_avail = ~q_empty;
  assign irq        = data_avail & irq_en;
endmodule

// File: rtl/mdrop_uart_rx_checker.sv
module mdrop_uart_rx_checker #(
  parameter int FIFO_DEPTH = 2
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           port_en,
  input logic                           rx_en,
  input logic                           nine_bit_en,
  input logic                           addr_match_en,
  input logic                           pop_stb,
  input logic                           irq,
  input logic                           overrun_err,
  input logic                           done,
  input logic                           b9,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] level
);
  assert_irq_needs_data_R12: assert property (@(posedge clk) disable iff (rst)
    irq |-> (level != '0));

  assert_ovr_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !overrun_err);

  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (overrun_err && rx_en) |=> overrun_err);

  assert_ovr_freezes_queue_R9: assert property (@(posedge clk) disable iff (rst)
    (overrun_err && rx_en && !pop_stb) |=> $stable(level));

  assert_inactive_no_frame_R11: assert property (@(posedge clk) disable iff (rst)
    !(port_en && rx_en) |=> !done);

  assert_filter_drops_R5: assert property (@(posedge clk) disable iff (rst)
    (done && nine_bit_en && addr_match_en && !b9 && !pop_stb) |=> $stable(level));

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (rst)
    32'(level) <= FIFO_DEPTH);
endmodule

bind mdrop_uart_rx mdrop_uart_rx_checker #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .port_en       (port_en),
  .rx_en         (rx_en),
  .nine_bit_en   (nine_bit_en),
  .addr_match_en (addr_match_en),
  .pop_stb       (pop_stb),
  .irq           (irq),
  .overrun_err   (overrun_err),
  .done          (f_done),
  .b9            (f_b9),
  .level         (fifo_level)
);

// File: tb/mdrop_uart_rx_tb.sv
`timescale 1ns/1ps
module mdrop_uart_rx_tb_top;
  localparam int DEPTH = 2;
  localparam int CPB   = 64;  // clocks per bit: 16 ticks x 4 clocks

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       sample_tick;
  logic       rx_line = 1'b1;
  logic       port_en = 1'b1, rx_en = 1'b1, nine_bit_en = 1'b0;
  logic       addr_match_en = 1'b0, irq_en = 1'b1, pop_stb = 1'b0;
  logic [7:0] head_data;
  logic       head_bit9, head_ferr, overrun_err, data_avail, irq;

  int n_chk = 0, n_fail = 0;
  bit running = 1'b0;
  bit ended = 1'b0;

  logic [1:0] tcnt = '0;
  always @(negedge clk) tcnt <= tcnt + 1'b1;
  assign sample_tick = (tcnt == 2'd0);

  mdrop_uart_rx dut_i (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .rx_line(rx_line),
    .port_en(port_en), .rx_en(rx_en), .nine_bit_en(nine_bit_en),
    .addr_match_en(addr_match_en), .irq_en(irq_en), .pop_stb(pop_stb),
    .head_data(head_data), .head_bit9(head_bit9), .head_ferr(head_ferr),
    .overrun_err(overrun_err), .data_avail(data_avail), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [9:0] mq[$];
  int  m_st, m_s, m_bi, m_nb;
  bit  m_s1, m_s2, m_va, m_vb, m_ovr;
  bit  m_done, m_b9, m_fe, dn_new, mtake, full_old, ovr_old, rxv, vote;
  logic [8:0] m_bits;
  logic [7:0] m_wd;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_st = 0; m_s = 0; m_bi = 0; m_s1 = 1; m_s2 = 1; m_va = 1; m_vb = 1;
      m_ovr = 0; m_done = 0; m_b9 = 0; m_fe = 0; m_bits = '0; m_wd = '0;
    end else begin
      mtake    = m_done && (!(nine_bit_en && addr_match_en) || m_b9);
      full_old = (mq.size() == DEPTH);
      ovr_old  = m_ovr;
      if (!rx_en) m_ovr = 0;
      else if (mtake && full_old && !ovr_old) m_ovr = 1;
      if (pop_stb && mq.size() > 0) void'(mq.pop_front());
      if (mtake && !ovr_old && !full_old) mq.push_back({m_fe, m_b9, m_wd});
      dn_new = 0;
      rxv = m_s2;
      m_nb = nine_bit_en ? 9 : 8;
      if (!(port_en && rx_en)) m_st = 0;
      else if (sample_tick) begin
        vote = (m_va && m_vb) || (m_va && rxv) || (m_vb && rxv);
        case (m_st)
          0: if (!rxv) begin m_st = 1; m_s = 1; end
          1: begin
            if (m_s == 7 && rxv) m_st = 0;
            else if (m_s == 15) begin m_st = 2; m_s = 0; m_bi = 0; end
            else m_s++;
          end
          2: begin
            if (m_s == 6) m_va = rxv;
            if (m_s == 7) m_vb = rxv;
            if (m_s == 8) m_bits[m_bi] = vote;
            if (m_s == 15) begin
              m_s = 0;
              if (m_bi == m_nb - 1) m_st = 3; else m_bi++;
            end else m_s++;
          end
          default: begin
            if (m_s == 6) m_va = rxv;
            if (m_s == 7) m_vb = rxv;
            if (m_s == 8) begin
              dn_new = 1; m_wd = m_bits[7:0];
              m_b9 = nine_bit_en && m_bits[8]; m_fe = !vote; m_st = 0;
            end else m_s++;
          end
        endcase
      end
      m_s2 = m_s1; m_s1 = rx_line;
      m_done = dn_new;
    end
  end

  // per-clock comparison, after outputs and model have settled
  always begin
    @(posedge clk); #1;
    if (running) begin
      chk(data_avail == (mq.size() > 0), "R12", "data_avail", data_avail, mq.size() > 0);
      chk(irq == ((mq.size() > 0) && irq_en), "R12", "irq", irq, (mq.size() > 0) && irq_en);
      chk(overrun_err == m_ovr, "R9", "overrun_err", overrun_err, m_ovr);
      if (mq.size() > 0)
        chk({head_ferr, head_bit9, head_data} == mq[0], "R8", "head entry",
            {head_ferr, head_bit9, head_data}, mq[0]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] w, input int nb, input logic stopv);
    rx_line = 1'b0; hold(CPB);
    for (int i = 0; i < nb; i++) begin rx_line = w[i]; hold(CPB); end
    rx_line = stopv; hold(CPB);
    rx_line = 1'b1; hold(2 * CPB);
  endtask

  // data bit 3 carries a one-tick inverted pulse near its centre
  task automatic send_spiked(input logic [7:0] w);
    rx_line = 1'b0; hold(CPB);
    for (int i = 0; i < 8; i++) begin
      rx_line = w[i];
      if (i == 3) begin
        hold(28); rx_line = ~w[i]; hold(4); rx_line = w[i]; hold(32);
      end else hold(CPB);
    end
    rx_line = 1'b1; hold(3 * CPB);
  endtask

  task automatic pop_expect(input logic [7:0] d, input logic b9, input logic fe,
                            input string tag);
    chk(data_avail == 1'b1, tag, "avail before pop", data_avail, 1);
    chk(head_data == d, tag, "head_data", head_data, d);
    chk(head_bit9 == b9, tag, "head_bit9", head_bit9, b9);
    chk(head_ferr == fe, tag, "head_ferr", head_ferr, fe);
    pop_stb = 1'b1; hold(1); pop_stb = 1'b0; hold(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    hold(6);
    rst = 1'b0;
    hold(1);
    // R13: reset state
    chk(data_avail == 0, "R13", "data_avail", data_avail, 0);
    chk(overrun_err == 0, "R13", "overrun_err", overrun_err, 0);
    chk(irq == 0, "R13", "irq", irq, 0);
    running = 1'b1;

    // R1: eight-bit frame, LSB first
    send(9'h0A5, 8, 1'b1);
    chk(irq == 1, "R12", "irq with data", irq, 1);
    pop_expect(8'hA5, 1'b0, 1'b0, "R1");
    chk(data_avail == 0, "R8", "empty after pop", data_avail, 0);

    // R12: interrupt gated by enable
    irq_en = 1'b0;
    send(9'h05A, 8, 1'b1);
    chk(irq == 0, "R12", "irq masked", irq, 0);
    chk(data_avail == 1, "R12", "avail masked", data_avail, 1);
    pop_expect(8'h5A, 1'b0, 1'b0, "R1");
    irq_en = 1'b1; hold(1);

    // R3: single wrong oversample is outvoted
    send_spiked(8'h96);
    pop_expect(8'h96, 1'b0, 1'b0, "R3");
    send_spiked(8'h08);
    pop_expect(8'h08, 1'b0, 1'b0, "R3");

    // R2: short low pulse is not a start bit
    rx_line = 1'b0; hold(20); rx_line = 1'b1; hold(3 * CPB);
    chk(data_avail == 0, "R2", "glitch gives no word", data_avail, 0);

    // R7: framing error tied to its word
    send(9'h033, 8, 1'b0);
    hold(CPB);
    send(9'h044, 8, 1'b1);
    pop_expect(8'h33, 1'b0, 1'b1, "R7");
    pop_expect(8'h44, 1'b0, 1'b0, "R7");

    // R4 / R6: nine-bit mode, filter off
    nine_bit_en = 1'b1;
    send(9'h13C, 9, 1'b1);
    pop_expect(8'h3C, 1'b1, 1'b0, "R4");
    send(9'h0C3, 9, 1'b1);
    pop_expect(8'hC3, 1'b0, 1'b0, "R6");

    // R5: address filter
    addr_match_en = 1'b1;
    send(9'h055, 9, 1'b1);
    chk(data_avail == 0, "R5", "data frame dropped", data_avail, 0);
    send(9'h1AA, 9, 1'b1);
    pop_expect(8'hAA, 1'b1, 1'b0, "R5");
    addr_match_en = 1'b0; nine_bit_en = 1'b0;

    // R8 / R9: fill, overrun, keep contents
    send(9'h011, 8, 1'b1);
    send(9'h022, 8, 1'b1);
    chk(overrun_err == 0, "R9", "no overrun at two", overrun_err, 0);
    send(9'h033, 8, 1'b1);
    chk(overrun_err == 1, "R9", "overrun set", overrun_err, 1);
    send(9'h044, 8, 1'b1);
    pop_expect(8'h11, 1'b0, 1'b0, "R8");
    pop_expect(8'h22, 1'b0, 1'b0, "R8");
    chk(data_avail == 0, "R9", "overrun words dropped", data_avail, 0);
    send(9'h055, 8, 1'b1);
    chk(data_avail == 0, "R9", "dropped while overrun", data_avail, 0);
    chk(overrun_err == 1, "R9", "overrun sticky", overrun_err, 1);

    // R10: clear through receive enable
    rx_en = 1'b0; hold(2);
    chk(overrun_err == 0, "R10", "overrun cleared", overrun_err, 0);
    rx_en = 1'b1; hold(1);
    send(9'h066, 8, 1'b1);
    pop_expect(8'h66, 1'b0, 1'b0, "R10");

    // R11: gating by port and receive enables
    port_en = 1'b0;
    send(9'h077, 8, 1'b1);
    chk(data_avail == 0, "R11", "port disabled", data_avail, 0);
    port_en = 1'b1; rx_en = 1'b0;
    send(9'h079, 8, 1'b1);
    chk(data_avail == 0, "R11", "receive disabled", data_avail, 0);
    rx_en = 1'b1; hold(1);
    send(9'h078, 8, 1'b1);
    pop_expect(8'h78, 1'b0, 1'b0, "R11");

    hold(4);
    running = 1'b0;
    finish_run();
  end
endmodule